// File: doc/BRIEF.md
# Tamper Timestamp Freeze Controller

This block sits between the running time counter of a real-time clock and the eight byte-wide time registers that software reads. It watches two tamper switch inputs. Each channel can be armed on its own and has a polarity setting for a switch that is normally closed or normally open. When an armed channel sees its switch in the tamper state for long enough, the block latches that channel's sticky flag. It also stops the software-visible time bytes from following the running time. The held bytes then tell software exactly when the first intrusion happened. The internal time keeps counting underneath. Once every channel is disarmed, the visible bytes jump back to the live time on the next clock.

The same hold mechanism serves a power-down timestamp. When power loss is signalled and no tamper channel is armed, a halt flag is set and the visible bytes freeze. Software clears that flag by writing it to zero. When at least one channel is armed, tamper timestamping has priority, and the power-loss signal leaves both the halt flag and the visible registers alone.

The register read port is a plain combinational lookup with no handshake. `rd_data_o` shows the visible byte selected by `rd_addr_i` in the same cycle. There is no back-pressure because the port only reads register contents and never consumes anything.

Top module: `rtc_tamper_freeze`

## Requirements
- R1: Out of reset, all tamper flags, the halt flag and the frozen indication are 0, and every visible time byte reads 0.
- R2: A channel whose mode bit is 0 (normally closed; input 1 means the switch is closed) treats input 0 as tamper. A channel whose mode bit is 1 (normally open) treats input 1 as tamper. The idle level of the selected mode never sets a flag.
- R3: Each tamper input passes through a two-stage synchronizer. The synchronized tamper condition must be present on `flt_len_i`+1 consecutive clock edges before it counts. A condition driven for only `flt_len_i` cycles is ignored.
- R4: A counted tamper on an armed channel sets its flag. The flag stays set for as long as that channel's enable bit is 1, and it clears on the edge after the enable bit is 0. A disarmed channel never raises its flag.
- R5: The first counted tamper freezes the visible time. The bytes hold the running time from before the edge that counted the tamper, so a tick on that same edge is excluded.
- R6: Later tampers, on the same channel or the other one, do not recapture the held time.
- R7: The visible time stays held until every enable bit is 0. On the next edge it reloads the live time, which has kept counting while held. If any channel is still armed, the time stays held.
- R8: A rising edge on `pwr_dn_i` while no channel is armed sets `halt_o` on that edge and freezes the visible time at its value before that edge.
- R9: A rising edge on `pwr_dn_i` while any channel is armed leaves `halt_o` at 0 and does not freeze the visible time.
- R10: A pulse on `halt_clr_i` clears `halt_o`. The visible time resumes only if no tamper freeze is in effect. Otherwise it keeps the held value.
- R11: The running time increases by 1 on every edge with `tick_i` high and holds otherwise. While not frozen, the visible time equals the running time.
- R12: `rd_data_o` returns visible byte number `rd_addr_i`. Byte 0 holds the least significant 8 bits of the time value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Advance the running time by one on this edge |
| tamper_i | input | NCH | Raw switch inputs, asynchronous |
| tamper_en_i | input | NCH | Per-channel arm bits |
| tamper_mode_i | input | NCH | Per-channel polarity: 0 normally closed, 1 normally open |
| flt_len_i | input | FLT_W | Glitch filter length in clock cycles |
| pwr_dn_i | input | 1 | Power-loss indication, synchronous level |
| halt_clr_i | input | 1 | Software clear of the halt flag, one-cycle pulse |
| rd_addr_i | input | AW | Visible time byte select |
| rd_data_o | output | REG_W | Selected visible time byte |
| tamper_flag_o | output | NCH | Sticky tamper flags |
| halt_o | output | 1 | Power-down halt flag |
| frozen_o | output | 1 | Visible time is being held |

## Verification
The checker evaluates several rules on every cycle:
- the visible time matches the running time whenever it is not held, and stays still whenever it is held;
- the running time counts exactly the ticks;
- a flag is never set without its arm bit, and once set it persists while the channel stays armed;
- a power-loss edge never sets the halt flag while a channel is armed;
- with nothing armed and no halt pending, the hold is released on the next edge.

Only the bench scenarios can show the behaviours that depend on history. These are the exact timestamp taken at the first tamper, the filter's reject or accept boundary for each filter length, both polarities on both channels, the second tamper leaving the timestamp unchanged, and a halt clear that has no effect while a tamper hold is active.

// File: rtl/rtf_pkg.sv
package rtf_pkg;
  typedef enum logic {
    TMODE_NC = 1'b0,
    TMODE_NO = 1'b1
  } tamper_mode_e;

  function automatic logic cond_active(input logic level, input logic mode);
    return (tamper_mode_e'(mode) == TMODE_NO) ? level : ~level;
  endfunction
endpackage

// File: rtl/rtf_tamper_chan.sv
module rtf_tamper_chan #(
  parameter int FLT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic [FLT_W-1:0] flt_len_i,
  output logic             flag_o,
  output logic             event_o
);
  import rtf_pkg::*;

  logic [1:0]       sync_q;
  logic [FLT_W-1:0] run_q;
  logic             flag_q;
  logic             active;
  logic             det;

  assign active  = cond_active(sync_q[1], mode_i);
  assign det     = en_i & active & (run_q >= flt_len_i);
  assign event_o = det & ~flag_q;
  assign flag_o  = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      run_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      if (!en_i || !active) begin
        run_q <= '0;
      end else if (run_q < flt_len_i) begin
        run_q <= run_q + 1'b1;
      end
      flag_q <= en_i & (flag_q | det);
    end
  end
endmodule

// File: rtl/rtf_freeze_ctl.sv
module rtf_freeze_ctl #(
  parameter int NCH = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] en_i,
  input  logic [NCH-1:0] evt_i,
  input  logic           pwr_dn_i,
  input  logic           halt_clr_i,
  output logic           halt_o,
  output logic           freeze_nxt_o,
  output logic           frozen_o
);
  logic any_en;
  logic tfrz_q, tfrz_nxt;
  logic halt_q, halt_nxt;
  logic pd_q, pd_rise;
  logic frozen_q;

  assign any_en   = |en_i;
  assign pd_rise  = pwr_dn_i & ~pd_q;
  assign tfrz_nxt = any_en & (tfrz_q | (|evt_i));
  assign halt_nxt = (halt_q & ~halt_clr_i) | (pd_rise & ~any_en);
  assign freeze_nxt_o = tfrz_nxt | halt_nxt;
  assign halt_o   = halt_q;
  assign frozen_o = frozen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tfrz_q   <= 1'b0;
      halt_q   <= 1'b0;
      pd_q     <= 1'b0;
      frozen_q <= 1'b0;
    end else begin
      tfrz_q   <= tfrz_nxt;
      halt_q   <= halt_nxt;
      pd_q     <= pwr_dn_i;
      frozen_q <= freeze_nxt_o;
    end
  end
endmodule

// File: rtl/rtf_time_bank.sv
module rtf_time_bank #(
  parameter int NREG  = 8,
  parameter int REG_W = 8,
  localparam int TIME_W = NREG * REG_W,
  localparam int AW     = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              freeze_nxt_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic [TIME_W-1:0] time_o,
  output logic [TIME_W-1:0] vis_o
);
  logic [TIME_W-1:0] time_q, time_d, vis_q;

  assign time_d = time_q + TIME_W'(tick_i);
  assign time_o = time_q;
  assign vis_o  = vis_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= '0;
      vis_q  <= '0;
    end else begin
      time_q <= time_d;
      if (!freeze_nxt_i) vis_q <= time_d;
    end
  end

  if (NREG == (1 << AW)) begin : g_full_map
    assign rd_data_o = vis_q[int'(rd_addr_i)*REG_W +: REG_W];
  end else begin : g_part_map
    assign rd_data_o = (int'(rd_addr_i) < NREG) ? vis_q[int'(rd_addr_i)*REG_W +: REG_W] : '0;
  end
endmodule

// File: rtl/rtc_tamper_freeze.sv
module rtc_tamper_freeze #(
  parameter int NCH   = 2,
  parameter int NREG  = 8,
  parameter int REG_W = 8,
  parameter int FLT_W = 4,
  localparam int TIME_W = NREG * REG_W,
  localparam int AW     = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [NCH-1:0]   tamper_i,
  input  logic [NCH-1:0]   tamper_en_i,
  input  logic [NCH-1:0]   tamper_mode_i,
  input  logic [FLT_W-1:0] flt_len_i,
  input  logic             pwr_dn_i,
  input  logic             halt_clr_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic [NCH-1:0]   tamper_flag_o,
  output logic             halt_o,
  output logic             frozen_o
);
  logic [NCH-1:0]    evt;
  logic              freeze_nxt;
  logic [TIME_W-1:0] time_w, vis_w;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    rtf_tamper_chan #(.FLT_W(FLT_W)) chan_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pin_i     (tamper_i[c]),
      .en_i      (tamper_en_i[c]),
      .mode_i    (tamper_mode_i[c]),
      .flt_len_i (flt_len_i),
      .flag_o    (tamper_flag_o[c]),
      .event_o   (evt[c])
    );
  end

  rtf_freeze_ctl #(.NCH(NCH)) ctl_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (tamper_en_i),
    .evt_i        (evt),
    .pwr_dn_i     (pwr_dn_i),
    .halt_clr_i   (halt_clr_i),
    .halt_o       (halt_o),
    .freeze_nxt_o (freeze_nxt),
    .frozen_o     (frozen_o)
  );

  rtf_time_bank #(.NREG(NREG), .REG_W(REG_W)) bank_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .freeze_nxt_i (freeze_nxt),
    .rd_addr_i    (rd_addr_i),
    .rd_data_o    (rd_data_o),
    .time_o       (time_w),
    .vis_o        (vis_w)
  );
endmodule

// File: rtl/rtc_tamper_freeze_chk.sv
module rtc_tamper_freeze_chk #(
  parameter int NCH    = 2,
  parameter int TIME_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [NCH-1:0]    tamper_en_i,
  input logic [NCH-1:0]    tamper_flag_o,
  input logic              pwr_dn_i,
  input logic              halt_o,
  input logic              frozen_o,
  input logic [TIME_W-1:0] time_q,
  input logic [TIME_W-1:0] vis_q
);
  // R4: a flag is only present when its channel was armed on the previous edge
  a_r4_flag_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((tamper_flag_o & ~$past(tamper_en_i)) == '0));

  // R4: a flag on an armed channel persists
  a_r4_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(tamper_flag_o) & $past(tamper_en_i) & ~tamper_flag_o) == '0));

  // R5: held visible time does not move
  a_r5_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_o |-> $stable(vis_q));

  // R11: visible time tracks running time when not held
  a_r11_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frozen_o |-> (vis_q == time_q));

  // R11: running time counts ticks exactly
  a_r11_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (time_q == $past(time_q) + TIME_W'(1)));

  a_r11_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(time_q));

  // R9: no halt flag from power loss while armed
  a_r9_no_halt_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && (|tamper_en_i)) |=> !halt_o);

  // R7: nothing armed and no halt pending releases the hold
  a_r7_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tamper_en_i == '0) && !halt_o && !pwr_dn_i) |=> !frozen_o);
endmodule

bind rtc_tamper_freeze rtc_tamper_freeze_chk #(.NCH(NCH), .TIME_W(TIME_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tick_i        (tick_i),
  .tamper_en_i   (tamper_en_i),
  .tamper_flag_o (tamper_flag_o),
  .pwr_dn_i      (pwr_dn_i),
  .halt_o        (halt_o),
  .frozen_o      (frozen_o),
  .time_q        (time_w),
  .vis_q         (vis_w)
);

// File: tb/rtc_tamper_freeze_tb_top.sv
`timescale 1ns/1ps
module rtc_tamper_freeze_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [1:0] tamper = 2'b11;
  logic [1:0] en = 2'b00;
  logic [1:0] mode = 2'b00;
  logic [3:0] flt = 4'd0;
  logic       pwr = 1'b0;
  logic       hclr = 1'b0;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;
  logic [1:0] flags;
  logic       halt, frozen;

  int n_vec = 0;
  int n_err = 0;
  logic [63:0] exp_time = '0;

  always #2.5 clk = ~clk;

  rtc_tamper_freeze dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .tamper_i(tamper),
    .tamper_en_i(en), .tamper_mode_i(mode), .flt_len_i(flt),
    .pwr_dn_i(pwr), .halt_clr_i(hclr), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .tamper_flag_o(flags), .halt_o(halt), .frozen_o(frozen)
  );

  always @(posedge clk) begin
    if (!rst_n) exp_time <= '0;
    else if (tick) exp_time <= exp_time + 64'd1;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_vis(output logic [63:0] v);
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      #0.1;
      v[a*8 +: 8] = rd_data;
    end
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    logic [63:0] v, t0, tstamp, snap;
    step(3);
    // R1 reset state
    read_vis(v);
    check("R1 vis", v, 64'd0);
    check("R1 flags", 64'(flags), 64'd0);
    check("R1 halt", 64'(halt), 64'd0);
    check("R1 frozen", 64'(frozen), 64'd0);
    rst_n = 1'b1;
    step(4);
    read_vis(v);
    check("R11 follow after reset", v, exp_time);

    // Sweep: channel x mode x filter length
    for (int c = 0; c < 2; c++) begin
      for (int m = 0; m < 2; m++) begin
        for (int len = 0; len < 4; len++) begin
          automatic int o = 1 - c;
          automatic logic idle = (m == 1) ? 1'b0 : 1'b1;
          en = 2'b00;
          mode[c] = 1'(m); mode[o] = 1'b0;
          tamper[c] = idle; tamper[o] = 1'b1;
          flt = 4'(len);
          step(3);
          en = 2'b11;
          step(3);
          check("R2 idle level no flag", 64'(flags), 64'd0);
          if (len > 0) begin
            tamper[c] = ~idle;
            step(len);
            tamper[c] = idle;
            step(len + 4);
            check("R3 short glitch rejected", 64'(flags), 64'd0);
            check("R3 no freeze on glitch", 64'(frozen), 64'd0);
          end
          tamper[c] = ~idle;
          t0 = exp_time;
          step(len + 4);
          check("R2 tamper flag set", 64'(flags[c]), 64'd1);
          check("R5 frozen", 64'(frozen), 64'd1);
          read_vis(v);
          tstamp = t0 + 64'(len) + 64'd2;
          check("R5 timestamp value", v, tstamp);
          tamper[o] = 1'b0;
          step(len + 4);
          check("R4 second channel flag", 64'(flags[o]), 64'd1);
          read_vis(v);
          check("R6 no recapture", v, tstamp);
          en[c] = 1'b0;
          step(2);
          check("R4 flag cleared by disarm", 64'(flags[c]), 64'd0);
          check("R7 still held while one armed", 64'(frozen), 64'd1);
          read_vis(v);
          check("R7 held value kept", v, tstamp);
          en[o] = 1'b0;
          step(1);
          read_vis(v);
          check("R7 reload live time", v, exp_time);
          check("R7 unfrozen", 64'(frozen), 64'd0);
          check("R4 all flags clear", 64'(flags), 64'd0);
          tamper[c] = idle; tamper[o] = 1'b1;
        end
      end
    end

    // R11 tick gating
    mode = 2'b00; tamper = 2'b11; en = 2'b00; flt = 4'd0;
    tick = 1'b0;
    step(1);
    read_vis(snap);
    check("R11 follow", snap, exp_time);
    step(5);
    read_vis(v);
    check("R11 no tick holds", v, snap);
    tick = 1'b1;
    step(3);
    read_vis(v);
    check("R11 ticks resume", v, snap + 64'd3);

    // R8 power-down halt with nothing armed
    t0 = exp_time;
    pwr = 1'b1;
    step(2);
    check("R8 halt set", 64'(halt), 64'd1);
    check("R8 frozen", 64'(frozen), 64'd1);
    read_vis(v);
    check("R8 halt timestamp", v, t0);
    rd_addr = 3'd1; #0.1;
    check("R12 byte1", 64'(rd_data), 64'(t0[15:8]));
    rd_addr = 3'd0; #0.1;
    check("R12 byte0", 64'(rd_data), 64'(t0[7:0]));
    hclr = 1'b1;
    step(1);
    hclr = 1'b0;
    check("R10 halt cleared", 64'(halt), 64'd0);
    read_vis(v);
    check("R10 resumed", v, exp_time);
    pwr = 1'b0;

    // R9 power-down while armed
    en = 2'b01;
    step(3);
    pwr = 1'b1;
    step(2);
    check("R9 no halt when armed", 64'(halt), 64'd0);
    check("R9 not frozen", 64'(frozen), 64'd0);
    read_vis(v);
    check("R9 follows", v, exp_time);
    tamper[1] = 1'b0;
    step(5);
    check("R4 disarmed channel ignored", 64'(flags), 64'd0);
    pwr = 1'b0; tamper[1] = 1'b1; en = 2'b00;
    step(3);

    // R10 halt clear while tamper hold active
    t0 = exp_time;
    pwr = 1'b1;
    step(2);
    en = 2'b01;
    tamper[0] = 1'b0;
    step(5);
    check("R2 flag during halt", 64'(flags), 64'd1);
    hclr = 1'b1;
    step(1);
    hclr = 1'b0;
    step(1);
    check("R10 halt clear", 64'(halt), 64'd0);
    check("R10 still frozen", 64'(frozen), 64'd1);
    read_vis(v);
    check("R10 keeps first timestamp", v, t0);
    en = 2'b00; tamper[0] = 1'b1;
    step(1);
    read_vis(v);
    check("R7 resume after all disarmed", v, exp_time);
    pwr = 1'b0;
    step(2);
    summary();
  end
endmodule